// File: doc/BRIEF.md
# Software-Stepped SPI Master Port

This block is an SPI master (mode 0 only) that sits on a small 8-bit processor bus. The serial clock has no divider behind it. Each bus write to the shift address flips a clock flip-flop, so software makes both edges of every bit. Two shift writes move one bit, and sixteen move one byte. Software sets the bit rate by how far apart it spaces those writes.

Transmit and receive use separate registers. A write to the data address loads the transmit byte, and its most significant bit appears on MOSI at once. A read of the same address returns the byte collected from MISO. A control address holds a device-select field and an enable bit. Together they drive eight active-low chip selects, and at most one of them is low at a time. Reset clears the enable bit, so no device is selected until software asks for one.

A typical transfer is:
1. Write the control address to select and enable a device.
2. Write the data address with the byte to send.
3. Make sixteen shift writes.
4. Read the data address to get the received byte.

Top module: `spi_step_port`

## Requirements
- R1: After reset: sclk is 0, mosi is 0, every cs_n bit is 1, bus_rdata is 0, and a control read returns 0.
- R2: Each write to address 1 (shift) inverts sclk in the following cycle. Odd-numbered writes raise it and even-numbered writes lower it. No other access changes sclk, however many idle cycles lie between accesses.
- R3: A write to address 0 (data) loads the transmit register. mosi shows bit 7 of the written byte from the next cycle.
- R4: On each falling sclk edge the transmit register shifts left with a zero fill, so mosi sends the byte MSB first. After eight falling edges mosi is 0.
- R5: On each rising sclk edge the receive register shifts left and takes miso into bit 0. After eight rising edges, a read of address 0 returns the eight sampled bits, with the first sample in bit 7.
- R6: A write to address 2 (control) stores bits [2:0] as the device select and bit 3 as the enable. Upper bits are ignored. A read of address 2 returns {4'b0, enable, select}.
- R7: From the cycle after a control write, cs_n[select] is 0 and all other bits are 1 when enable is 1. When enable is 0, all cs_n bits are 1.
- R8: bus_rdata is registered. It is updated in the cycle after a read strobe and otherwise holds its value. A read of address 3 returns 0.
- R9: A write to address 3 changes no state: sclk, mosi, cs_n and the control readback keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register address (0 data, 1 shift, 2 control, 3 reserved) |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 8 | Active-low device selects |

## Verification
The bench builds the block with its default parameters: an 8-bit data path and a 3-bit select, giving eight chip selects. This small size lets the bench sweep all 256 transmit bytes, each paired with a received byte computed arithmetically. It checks MOSI before every rising edge, SCLK after every shift write, and the received byte after each transfer. The gaps between shift writes vary from byte to byte. It also writes all 256 control values and checks both the readback and the full chip-select vector for each one. This covers every select with the enable both set and clear.

// File: rtl/spi_step_pkg.sv
package spi_step_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_DATA  = 2'd0,
    REG_SHIFT = 2'd1,
    REG_CTRL  = 2'd2,
    REG_RSVD  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/spi_step_clk.sv
// Toggle flip-flop for the serial clock, stepped by bus writes.
module spi_step_clk (
  input  logic clk,
  input  logic rst,
  input  logic step,
  output logic sclk,
  output logic rise,
  output logic fall
);
  assign rise = step & ~sclk;
  assign fall = step & sclk;

  always_ff @(posedge clk) begin
    if (rst)       sclk <= 1'b0;
    else if (step) sclk <= ~sclk;
  end
endmodule

// File: rtl/spi_step_tx.sv
// Parallel-in, serial-out transmit register, MSB first.
module spi_step_tx #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  output logic         mosi
);
  logic [W-1:0] q;

  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (load)  q <= load_val;
    else if (shift) q <= {q[W-2:0], 1'b0};
  end

  assign mosi = q[W-1];
endmodule

// File: rtl/spi_step_rx.sv
// Serial-in, parallel-out receive register.
module spi_step_rx #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sample,
  input  logic         din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)         q <= '0;
    else if (sample) q <= {q[W-2:0], din};
  end
endmodule

// File: rtl/spi_step_csdec.sv
// Registered one-hot active-low decoder, gated by an enable.
module spi_step_csdec #(
  parameter int SEL_W = 3,
  localparam int NCS  = 1 << SEL_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd,
  input  logic             en,
  input  logic [SEL_W-1:0] sel,
  output logic [NCS-1:0]   cs_n
);
  for (genvar i = 0; i < NCS; i++) begin : g_cs
    always_ff @(posedge clk) begin
      if (rst)      cs_n[i] <= 1'b1;
      else if (upd) cs_n[i] <= ~(en && (sel == SEL_W'(i)));
    end
  end
endmodule

// File: rtl/spi_step_port.sv
module spi_step_port
  import spi_step_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SEL_W  = 3,
  localparam int NCS   = 1 << SEL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [NCS-1:0]    cs_n
);
  logic wr_data, wr_shift, wr_ctrl;
  logic rise, fall;
  logic [DATA_W-1:0] rx_q;
  logic [SEL_W-1:0]  sel_q;
  logic              en_q;
  logic [DATA_W-1:0] ctrl_rb;

  assign wr_data  = bus_wr && (bus_addr == REG_DATA);
  assign wr_shift = bus_wr && (bus_addr == REG_SHIFT);
  assign wr_ctrl  = bus_wr && (bus_addr == REG_CTRL);

  spi_step_clk u_clk (
    .clk (clk), .rst (rst), .step (wr_shift),
    .sclk(sclk), .rise(rise), .fall(fall)
  );

  spi_step_tx #(.W(DATA_W)) u_tx (
    .clk(clk), .rst(rst), .load(wr_data), .load_val(bus_wdata),
    .shift(fall), .mosi(mosi)
  );

  spi_step_rx #(.W(DATA_W)) u_rx (
    .clk(clk), .rst(rst), .sample(rise), .din(miso), .q(rx_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
      en_q  <= 1'b0;
    end else if (wr_ctrl) begin
      sel_q <= bus_wdata[SEL_W-1:0];
      en_q  <= bus_wdata[SEL_W];
    end
  end

  spi_step_csdec #(.SEL_W(SEL_W)) u_cs (
    .clk(clk), .rst(rst), .upd(wr_ctrl),
    .en(bus_wdata[SEL_W]), .sel(bus_wdata[SEL_W-1:0]), .cs_n(cs_n)
  );

  assign ctrl_rb = DATA_W'({en_q, sel_q});

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_rd) begin
      case (bus_addr)
        REG_DATA: bus_rdata <= rx_q;
        REG_CTRL: bus_rdata <= ctrl_rb;
        default:  bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/spi_step_chk.sv
module spi_step_chk
  import spi_step_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NCS    = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              sclk,
  input logic              mosi,
  input logic [NCS-1:0]    cs_n
);
  a_r2_shift_toggles: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == REG_SHIFT) |=> (sclk != $past(sclk)));

  a_r2_sclk_holds: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && bus_addr == REG_SHIFT) |=> $stable(sclk));

  a_r4_mosi_moves_on_fall: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && (bus_addr == REG_DATA || (bus_addr == REG_SHIFT && sclk)))
    |=> $stable(mosi));

  a_r7_cs_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~cs_n));

  a_r1_cs_idle_after_reset: assert property (@(posedge clk)
    rst |=> (&cs_n));

  a_r8_rdata_holds: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));
endmodule

bind spi_step_port spi_step_chk #(.DATA_W(DATA_W), .NCS(NCS)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_rd(bus_rd), .bus_rdata(bus_rdata), .sclk(sclk), .mosi(mosi),
  .cs_n(cs_n)
);

// File: tb/tb_spi_step_port.sv
`timescale 1ns/1ps
module tb_spi_step_port;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       sclk, mosi;
  logic       miso = 1'b0;
  logic [7:0] cs_n;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  spi_step_port dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] r, t, m, v, cs_exp, hold;
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 sclk", sclk, 0);
    chk("R1 mosi", mosi, 0);
    chk("R1 cs_n", cs_n, 8'hFF);
    chk("R1 rdata", bus_rdata, 0);
    rd(2'd2, r); chk("R1 ctrl", r, 0);

    // R6 R7 control sweep
    for (int i = 0; i < 256; i++) begin
      v = 8'(i);
      wr(2'd2, v);
      cs_exp = v[3] ? ~(8'd1 << v[2:0]) : 8'hFF;
      chk("R7 cs_n", cs_n, cs_exp);
      rd(2'd2, r);
      chk("R6 readback", r, {4'b0, v[3:0]});
    end

    // R2 R3 R4 R5 byte sweep with varying gaps
    wr(2'd2, 8'h0D);
    for (int i = 0; i < 256; i++) begin
      t = 8'(i);
      m = 8'((i * 7 + 93) & 255);
      wr(2'd0, t);
      chk("R3 first bit", mosi, t[7]);
      for (int b = 7; b >= 0; b--) begin
        miso = m[b];
        chk("R4 mosi bit", mosi, t[b]);
        wr(2'd1, 8'h00);
        chk("R2 rise", sclk, 1);
        idle(i % 4);
        chk("R2 gap hold", sclk, 1);
        wr(2'd1, 8'h00);
        chk("R2 fall", sclk, 0);
        idle((i + 1) % 3);
      end
      chk("R4 drained", mosi, 0);
      rd(2'd0, r);
      chk("R5 rx byte", r, m);
    end

    // R8 hold and reserved read
    rd(2'd0, hold);
    wr(2'd0, 8'hA5);
    wr(2'd2, 8'h0A);
    idle(2);
    chk("R8 rdata holds", bus_rdata, hold);
    rd(2'd3, r); chk("R8 reserved read", r, 0);

    // R9 reserved write ignored
    wr(2'd1, 8'h00);
    wr(2'd3, 8'hFF);
    chk("R9 sclk", sclk, 1);
    chk("R9 mosi", mosi, 1);
    chk("R9 cs_n", cs_n, 8'hFB);
    rd(2'd2, r); chk("R9 ctrl", r, 8'h0A);
    wr(2'd1, 8'h00);
    chk("R4 after fall", mosi, 0);

    // R1 reset mid-transfer
    wr(2'd1, 8'h00);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R1 re-reset sclk", sclk, 0);
    chk("R1 re-reset cs_n", cs_n, 8'hFF);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule